// File: doc/BRIEF.md
# Optical Black Clamp Averager

This block derives the DC black reference for each video line. An optical-black marker pulse arrives once per line. The block first passes the marker through a two-flop synchronizer and looks for its rising edge. On that edge it opens a fixed slot of eight pixel clocks, placed a set distance after the edge, and adds up the black-level samples that fall inside the slot. It then publishes their mean as the clamp level. The level is held until a later marker produces a new one.

A marker that stays high for too few clocks is treated as a glitch. It is dropped, and the published level does not change. While a slot is open, any new marker edge is ignored.

The sample input has no valid/ready pair, because one sample arrives on every pixel clock and a slot cannot be stalled. The output works like a stream beat with valid only. The one-cycle update strobe marks the cycle in which a new level appears. There is no ready and no back-pressure, so a consumer must capture the level on the strobe or read it any time before the next strobe.

Top module: `ob_clamp_avg`

## Requirements
- R1: The marker `obp` is synchronized by two flops. Call the clock in which the synchronized rising edge is first seen N. The averaged samples are the `smp_data` values present in clocks N+5 through N+12. If `obp` rises just before posedge P0, these are the values captured at posedges P7 through P14.
- R2: The published level equals the sum of exactly eight samples, held to 13 bits, shifted right by 3 with truncation.
- R3: Eight full-scale samples of 1023 give a level of 1023, with no wrap of the sum.
- R4: A marker that is high for 2 clocks or fewer starts no average. It raises no strobe and leaves `clamp_lvl` unchanged. A marker that is high for 3 clocks is accepted.
- R5: A new marker rising edge that arrives while a slot is open is ignored. This holds even when the edge lands in the last sample clock. Only the level of the first slot is published.
- R6: `clamp_upd` is high for exactly one clock, the clock after the eighth sample, and `clamp_lvl` takes its new value in that same clock. In every other clock `clamp_lvl` holds its value.
- R7: A synchronized marker edge that lands in the clock where `clamp_upd` is high is accepted, and it starts a new slot.
- R8: While `rst_n` is low, and right after it is released, `clamp_lvl` is 0, `clamp_upd` is 0, and no slot is open.
- R9: Samples outside the eight-clock slot have no effect on the published level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obp | input | 1 | Optical-black marker, asynchronous |
| smp_data | input | 10 | Black-level sample, one per clock |
| clamp_lvl | output | 10 | Averaged clamp reference, held between updates |
| clamp_upd | output | 1 | One-clock strobe marking a new clamp level |

## Verification
Two functions can fall in the same clock. One is publishing a finished average. The other is deciding whether a fresh marker edge opens a new slot. The bench places a second marker so that its synchronized edge lands exactly in the strobe clock, and expects a second strobe 13 clocks later carrying the mean of the later eight samples. It then moves that edge one clock earlier, into the last sample clock, and expects no second strobe and an unchanged level.

// File: rtl/ob_clamp_pkg.sv
package ob_clamp_pkg;
  localparam int OBC_DATA_W     = 10;
  localparam int OBC_NSAMP_LOG2 = 3;
  localparam int OBC_WIN_START  = 5;
  localparam int OBC_MIN_HIGH   = 3;
  localparam int OBC_SYNC_STG   = 2;

  function automatic int obc_win_end(input int start, input int nlog2);
    return start + (1 << nlog2) - 1;
  endfunction
endpackage

// File: rtl/ob_pulse_sync.sv
module ob_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic obp_raw,
  output logic obp_lvl,
  output logic obp_rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], obp_raw};
  end

  assign obp_lvl  = shreg[STAGES-1];
  assign obp_rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/ob_window_ctrl.sv
module ob_window_ctrl #(
  parameter int WIN_START = 5,
  parameter int NSAMP_LOG2 = 3,
  parameter int MIN_HIGH = 3,
  localparam int WIN_END = WIN_START + (1 << NSAMP_LOG2) - 1,
  localparam int PH_W = $clog2(WIN_END + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            obp_lvl,
  input  logic            obp_rise,
  output logic [PH_W-1:0] phase,
  output logic            take,
  output logic            take_first,
  output logic            take_last
);
  logic idle;
  logic qualifying;

  assign idle       = (phase == '0);
  assign qualifying = !idle && (phase < PH_W'(MIN_HIGH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (idle) begin
      if (obp_rise) phase <= PH_W'(1);
    end else if (qualifying && !obp_lvl) begin
      phase <= '0;
    end else if (take_last) begin
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  assign take       = (phase >= PH_W'(WIN_START)) && (phase <= PH_W'(WIN_END));
  assign take_first = (phase == PH_W'(WIN_START));
  assign take_last  = (phase == PH_W'(WIN_END));
endmodule

// File: rtl/ob_accum.sv
module ob_accum #(
  parameter int DATA_W = 10,
  parameter int NSAMP_LOG2 = 3,
  localparam int SUM_W = DATA_W + NSAMP_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_first,
  input  logic              take_last,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] level,
  output logic              level_upd
);
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] acc_nxt;
  logic [SUM_W-1:0] mean_w;

  assign acc_nxt = (take_first ? '0 : acc) + SUM_W'(din);
  assign mean_w  = acc_nxt >> NSAMP_LOG2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      level     <= '0;
      level_upd <= 1'b0;
    end else begin
      level_upd <= 1'b0;
      if (take) acc <= acc_nxt;
      if (take && take_last) begin
        level     <= mean_w[DATA_W-1:0];
        level_upd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ob_clamp_avg.sv
module ob_clamp_avg
  import ob_clamp_pkg::*;
#(
  parameter int DATA_W     = OBC_DATA_W,
  parameter int NSAMP_LOG2 = OBC_NSAMP_LOG2,
  parameter int WIN_START  = OBC_WIN_START,
  parameter int MIN_HIGH   = OBC_MIN_HIGH,
  parameter int SYNC_STG   = OBC_SYNC_STG,
  localparam int WIN_END   = obc_win_end(WIN_START, NSAMP_LOG2),
  localparam int PH_W      = $clog2(WIN_END + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obp,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] clamp_lvl,
  output logic              clamp_upd
);
  logic            obp_lvl;
  logic            obp_rise;
  logic [PH_W-1:0] phase;
  logic            take;
  logic            take_first;
  logic            take_last;

  ob_pulse_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .obp_raw  (obp),
    .obp_lvl  (obp_lvl),
    .obp_rise (obp_rise)
  );

  ob_window_ctrl #(
    .WIN_START  (WIN_START),
    .NSAMP_LOG2 (NSAMP_LOG2),
    .MIN_HIGH   (MIN_HIGH)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .obp_lvl    (obp_lvl),
    .obp_rise   (obp_rise),
    .phase      (phase),
    .take       (take),
    .take_first (take_first),
    .take_last  (take_last)
  );

  ob_accum #(
    .DATA_W     (DATA_W),
    .NSAMP_LOG2 (NSAMP_LOG2)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_first (take_first),
    .take_last  (take_last),
    .din        (smp_data),
    .level      (clamp_lvl),
    .level_upd  (clamp_upd)
  );
endmodule

// File: rtl/ob_clamp_avg_chk.sv
module ob_clamp_avg_chk #(
  parameter int DATA_W = 10,
  parameter int PH_W = 4,
  parameter int WIN_END = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd,
  input logic [DATA_W-1:0] clamp,
  input logic [PH_W-1:0]   phase,
  input logic              lvl
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd); // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clamp) |-> upd); // R6
  AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_W'(WIN_END)) |=> upd); // R6
  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ($past(phase) == PH_W'(WIN_END))); // R6
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_W'(3)) |-> ($past(lvl, 1) && $past(lvl, 2) && $past(lvl, 3))); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase >= PH_W'(3)) && (phase < PH_W'(WIN_END))) |=> (phase == $past(phase) + PH_W'(1))); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> ((clamp == '0) && !upd && (phase == '0))); // R8
endmodule

bind ob_clamp_avg ob_clamp_avg_chk #(
  .DATA_W  (DATA_W),
  .PH_W    (PH_W),
  .WIN_END (WIN_END)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .upd   (clamp_upd),
  .clamp (clamp_lvl),
  .phase (phase),
  .lvl   (obp_lvl)
);

// File: tb/ob_clamp_avg_test.sv
`timescale 1ns/1ps
module ob_clamp_avg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       obp = 1'b0;
  logic [9:0] smp_data = '0;
  logic [9:0] clamp_lvl;
  logic       clamp_upd;
  int n_chk = 0;
  int n_bad = 0;
  int cur_exp = 0;

  always #2.5 clk = ~clk;

  ob_clamp_avg uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .obp       (obp),
    .smp_data  (smp_data),
    .clamp_lvl (clamp_lvl),
    .clamp_upd (clamp_upd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [39:0] hi(input int a, input int b);
    bit [39:0] m = '0;
    for (int i = a; i <= b; i++) m[i] = 1'b1;
    return m;
  endfunction

  // mode 0: ramp, mode 1: full scale, mode 2: small inside slot, full scale outside
  function automatic int dval(input int mode, input int k);
    case (mode)
      0: return 100 + 3 * k;
      1: return 1023;
      default: return (k >= 7 && k <= 14) ? k : 1023;
    endcase
  endfunction

  // mean of the samples captured at posedges k-7 .. k (R1, R2)
  function automatic int avg(input int mode, input int k);
    int s = 0;
    for (int i = k - 7; i <= k; i++) s += dval(mode, i);
    return s / 8;
  endfunction

  task automatic play(input string req, input bit [39:0] opat, input int mode,
                      input bit [39:0] upat);
    for (int k = 0; k < 40; k++) begin
      obp = opat[k];
      smp_data = 10'(dval(mode, k));
      @(negedge clk);
      chk({req, " strobe"}, int'(clamp_upd), int'(upat[k]));
      if (upat[k]) cur_exp = avg(mode, k);
      chk({req, " level"}, int'(clamp_lvl), cur_exp);
    end
  endtask

  task automatic t_reset();
    chk("R8 level in reset", int'(clamp_lvl), 0);
    chk("R8 strobe in reset", int'(clamp_upd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 level after release", int'(clamp_lvl), 0);
    chk("R8 strobe after release", int'(clamp_upd), 0);
  endtask

  task automatic t_ramp();     play("R1 R2 R6 ramp", hi(0, 5), 0, hi(14, 14)); endtask
  task automatic t_full();     play("R3 full scale", hi(0, 5), 1, hi(14, 14)); endtask
  task automatic t_outside();  play("R9 outside slot", hi(0, 5), 2, hi(14, 14)); endtask
  task automatic t_short();    play("R4 two-clock pulse", hi(0, 1), 0, '0); endtask
  task automatic t_minimum();  play("R4 three-clock pulse", hi(0, 2), 2, hi(14, 14)); endtask
  task automatic t_mid_edge(); play("R5 edge mid slot", hi(0, 3) | hi(5, 9), 0, hi(14, 14)); endtask
  task automatic t_last_edge();play("R5 edge at last sample", hi(0, 5) | hi(12, 17), 1, hi(14, 14)); endtask
  task automatic t_b2b();      play("R7 edge at strobe", hi(0, 5) | hi(13, 18), 0, hi(14, 14) | hi(27, 27)); endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ramp();
    t_full();
    t_outside();
    t_short();
    t_minimum();
    t_mid_edge();
    t_last_edge();
    t_b2b();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule